// File: doc/BRIEF.md
# Field Memory Write Port Controller

This block is the write side of a serial field memory used as an adjustable digital delay line. One write clock drives it. On each edge it samples a write-reset strobe, a write enable, an input enable and a byte of data. From these it keeps a wrapping write pointer and issues registered write strobes into a storage array it contains. The input enable masks single locations while the pointer keeps moving, which supports picture-in-picture style overlays. The write enable freezes the pointer entirely.

Two straps are captured while the block reset is high and are then treated as fixed. The first strap makes every control input active-low. The second, the cascade strap, delays each access by one clock, so that chained devices line up without external delay stages. The block also has these outputs:
- a flag that shows a write run has reached its minimum length after the last write reset;
- a sticky flag for write-reset pulses spaced too closely;
- a sticky flag for a strap that moved after it was captured;
- the live write pointer, so that a read-side monitor can measure the write-to-read distance.

The pointer is ADDR_W bits wide (18 by default, covering 262,144 locations). The storage array is a window of 2**MEM_AW words, indexed by the low pointer bits, and has a registered read port for read-back.

Top module: `field_wr_port`

## Requirements
- R1: While `rst` is high and after it falls, `wr_ptr_o` is 0 and `mem_we_o`, `run_ok_o`, `space_err_o` and `strap_err_o` are all 0.
- R2: A cycle with the write reset active sets the pointer to 0 and writes nothing, whatever the two enables and the data are.
- R3: A cycle with the write enable inactive (reset inactive) leaves the pointer unchanged and writes nothing, for either level of the input enable.
- R4: With the write enable active and the input enable inactive, the pointer advances by one and the location it addressed keeps its previous contents.
- R5: With both enables active, the data byte is stored at the current pointer and the pointer advances by one. Stored data is returned on `rd_data_o` one clock after its address is placed on `rd_addr_i`.
- R6: When `strap_act_low` was 1 at block reset, all three controls are taken as active at logic 0. When it was 0, they are active at logic 1.
- R7: When `strap_late` was 0 at block reset, a control sampled on an edge takes effect on that edge. When it was 1, it takes effect on the following edge.
- R8: `run_ok_o` becomes 1 once 80 (MIN_RUN) cycles with both enables active have been applied since the last write reset. It stays 1 until the next write reset clears it.
- R9: If a write reset becomes active after fewer than two inactive cycles since the previous one ended, `space_err_o` is set and stays set until block reset.
- R10: The pointer wraps from 2**ADDR_W-1 to 0.
- R11: If either strap input differs from its captured value while `rst` is low, `strap_err_o` is set and stays set until block reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high block reset; straps captured while high |
| strap_act_low | input | 1 | Control polarity strap (1 = active-low controls) |
| strap_late | input | 1 | Cascade strap (1 = access one clock later) |
| wr_rst_i | input | 1 | Write pointer reset request |
| wr_en_i | input | 1 | Write enable; inactive freezes the pointer |
| in_en_i | input | 1 | Input enable; inactive masks the store only |
| din_i | input | DATA_W | Write data |
| rd_addr_i | input | MEM_AW | Read-back address into the storage window |
| rd_data_o | output | DATA_W | Registered read-back data |
| wr_ptr_o | output | ADDR_W | Current write pointer |
| mem_we_o | output | 1 | Registered memory write strobe |
| mem_addr_o | output | ADDR_W | Registered memory write address |
| mem_wdata_o | output | DATA_W | Registered memory write data |
| run_ok_o | output | 1 | Minimum active-run length reached |
| space_err_o | output | 1 | Sticky write-reset spacing violation |
| strap_err_o | output | 1 | Sticky strap-change error |

## Verification
The bench is built with a 64-word pointer and a 64-word window. It runs the same stimulus under all four strap combinations. Each run contains:
- a full sweep that stores a distinct arithmetic pattern in every location, so the pointer must wrap;
- a second sweep that alternates masked and unmasked writes of a different pattern, so read-back shows which locations were protected;
- held cycles with only the input enable active, which separate a frozen pointer from a masked one;
- a write reset taken with both enables active, which tells an ignored store apart from a leaked one.

A run of exactly 80 stored cycles checks the run-length flag at its edge. Back-to-back reset pulses and a strap toggle check the two sticky flags.

// File: rtl/fmw_pkg.sv
package fmw_pkg;
  typedef struct packed {
    logic rst;
    logic we;
    logic ie;
  } wctl_t;
endpackage

// File: rtl/fmw_ctl_stage.sv
module fmw_ctl_stage #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strap_act_low,
  input  logic                strap_late,
  input  logic                wr_rst_i,
  input  logic                wr_en_i,
  input  logic                in_en_i,
  input  logic [DATA_W-1:0]   din_i,
  output fmw_pkg::wctl_t      ctl_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                strap_err_o
);
  import fmw_pkg::*;

  logic              pol_q, late_q, past_ok;
  wctl_t             dec, dly_q;
  logic [DATA_W-1:0] dly_d;

  // polarity decode: XOR with the captured strap
  assign dec.rst = wr_rst_i ^ pol_q;
  assign dec.we  = wr_en_i  ^ pol_q;
  assign dec.ie  = in_en_i  ^ pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q       <= strap_act_low;
      late_q      <= strap_late;
      dly_q       <= '0;
      dly_d       <= '0;
      past_ok     <= 1'b0;
      strap_err_o <= 1'b0;
    end else begin
      dly_q   <= dec;
      dly_d   <= din_i;
      past_ok <= 1'b1;
      if ({strap_act_low, strap_late} != {pol_q, late_q})
        strap_err_o <= 1'b1;
    end
  end

  // cascade select: current decode or one-cycle delayed copy
  assign ctl_o  = late_q ? dly_q : dec;
  assign data_o = late_q ? dly_d : din_i;

  // R7: in cascade mode the applied controls are those sampled one edge earlier
  p_late_r7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && late_q) |-> (ctl_o == $past(dec)));
  // R11: a strap mismatch raises the error on the next edge
  p_strap_set_r11: assert property (@(posedge clk) disable iff (rst)
    ({strap_act_low, strap_late} != {pol_q, late_q}) |=> strap_err_o);
  // R11: the error is sticky
  p_strap_hold_r11: assert property (@(posedge clk) disable iff (rst)
    strap_err_o |=> strap_err_o);
endmodule

// File: rtl/fmw_ptr_unit.sv
module fmw_ptr_unit #(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int MIN_RUN = 80
) (
  input  logic                clk,
  input  logic                rst,
  input  fmw_pkg::wctl_t      ctl_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [ADDR_W-1:0]   ptr_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                run_ok_o,
  output logic                space_err_o
);
  localparam int CNT_W = $clog2(MIN_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_TOP = CNT_W'(MIN_RUN);

  logic             adv, wr, prev_rst;
  logic [CNT_W-1:0] run_cnt;
  logic [1:0]       gap;

  assign adv = !ctl_i.rst && ctl_i.we;
  assign wr  = adv && ctl_i.ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_o       <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      run_cnt     <= '0;
      prev_rst    <= 1'b0;
      gap         <= 2'd2;
      space_err_o <= 1'b0;
    end else begin
      prev_rst    <= ctl_i.rst;
      mem_we_o    <= wr;
      mem_addr_o  <= ptr_o;
      mem_wdata_o <= data_i;
      if (ctl_i.rst) begin
        ptr_o   <= '0;
        run_cnt <= '0;
      end else if (adv) begin
        ptr_o <= ptr_o + 1'b1;
        if (wr && run_cnt != RUN_TOP)
          run_cnt <= run_cnt + 1'b1;
      end
      // count inactive cycles between write resets, saturating at two
      if (ctl_i.rst)
        gap <= 2'd0;
      else if (gap != 2'd2)
        gap <= gap + 2'd1;
      if (ctl_i.rst && !prev_rst && gap != 2'd2)
        space_err_o <= 1'b1;
    end
  end

  assign run_ok_o = (run_cnt == RUN_TOP);

  // R2: reset cycle zeroes the pointer and stores nothing
  p_rst_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_i.rst |=> (ptr_o == '0) && !mem_we_o);
  // R3: disabled write holds the pointer and stores nothing
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctl_i.rst && !ctl_i.we) |=> $stable(ptr_o) && !mem_we_o);
  // R4: enabled write advances the pointer by one, wrapping (R10)
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl_i.rst && ctl_i.we) |=> ((ptr_o - $past(ptr_o)) == ADDR_W'(1)));
  // R4: masked cycle issues no store
  p_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl_i.rst && ctl_i.we && !ctl_i.ie) |=> !mem_we_o);
  // R5: full write stores at the pointer held before the edge
  p_write_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctl_i.rst && ctl_i.we && ctl_i.ie) |=> mem_we_o && (mem_addr_o == $past(ptr_o)));
  // R8: write reset clears the run flag
  p_runclr_r8: assert property (@(posedge clk) disable iff (rst)
    ctl_i.rst |=> !run_ok_o);
  // R9: spacing error is sticky
  p_space_hold_r9: assert property (@(posedge clk) disable iff (rst)
    space_err_o |=> space_err_o);
endmodule

// File: rtl/fmw_store.sv
module fmw_store #(
  parameter int ADDR_W = 18,
  parameter int MEM_AW = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [MEM_AW-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [MEM_AW-1:0] wsel;

  assign wsel = waddr_i[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (we_i)
      mem[wsel] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/field_wr_port.sv
module field_wr_port #(
  parameter int ADDR_W  = 18,
  parameter int MEM_AW  = 10,
  parameter int DATA_W  = 8,
  parameter int MIN_RUN = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_act_low,
  input  logic              strap_late,
  input  logic              wr_rst_i,
  input  logic              wr_en_i,
  input  logic              in_en_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              run_ok_o,
  output logic              space_err_o,
  output logic              strap_err_o
);
  import fmw_pkg::*;

  wctl_t             ctl;
  logic [DATA_W-1:0] data;

  fmw_ctl_stage #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst),
    .strap_act_low(strap_act_low), .strap_late(strap_late),
    .wr_rst_i(wr_rst_i), .wr_en_i(wr_en_i), .in_en_i(in_en_i), .din_i(din_i),
    .ctl_o(ctl), .data_o(data), .strap_err_o(strap_err_o)
  );

  fmw_ptr_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_RUN(MIN_RUN)) u_ptr (
    .clk(clk), .rst(rst), .ctl_i(ctl), .data_i(data),
    .ptr_o(wr_ptr_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .run_ok_o(run_ok_o), .space_err_o(space_err_o)
  );

  fmw_store #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we_i(mem_we_o), .waddr_i(mem_addr_o), .wdata_i(mem_wdata_o),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  // R1: outputs are quiet right after block reset
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (wr_ptr_o == '0) && !mem_we_o && !run_ok_o && !space_err_o && !strap_err_o);
endmodule

// File: tb/field_wr_port_bench.sv
module field_wr_port_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int MIN_RUN = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_act_low = 1'b0, strap_late = 1'b0;
  logic wr_rst_i = 1'b0, wr_en_i = 1'b0, in_en_i = 1'b0;
  logic [7:0] din_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [AW-1:0] wr_ptr_o, mem_addr_o;
  logic mem_we_o, run_ok_o, space_err_o, strap_err_o;
  logic [7:0] mem_wdata_o;

  field_wr_port #(.ADDR_W(AW), .MEM_AW(AW), .DATA_W(8), .MIN_RUN(MIN_RUN)) u_field_wr_port (
    .clk(clk), .rst(rst), .strap_act_low(strap_act_low), .strap_late(strap_late),
    .wr_rst_i(wr_rst_i), .wr_en_i(wr_en_i), .in_en_i(in_en_i), .din_i(din_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .wr_ptr_o(wr_ptr_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .run_ok_o(run_ok_o), .space_err_o(space_err_o), .strap_err_o(strap_err_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit pol, late;
  bit pr, pw, pi;
  logic [7:0] pd;
  logic [AW-1:0] eptr;
  logic [7:0] emem [DEPTH];
  int ecnt;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic blk_reset(input bit p, input bit l);
    pol = p; late = l;
    rst = 1'b1;
    strap_act_low = p; strap_late = l;
    wr_rst_i = p; wr_en_i = p; in_en_i = p;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pointer in reset", int'(wr_ptr_o), 0);
    rst = 1'b0;
    pr = 0; pw = 0; pi = 0; pd = '0; eptr = '0; ecnt = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 pointer after reset", int'(wr_ptr_o), 0);
    chk("R1 run flag", int'(run_ok_o), 0);
    chk("R1 spacing flag", int'(space_err_o), 0);
    chk("R1 strap flag", int'(strap_err_o), 0);
    chk("R1 write strobe", int'(mem_we_o), 0);
  endtask

  // drives logical controls at a falling edge, models the applied effect (R6 R7)
  task automatic step(input bit r, input bit w, input bit i, input logic [7:0] d,
                      input string tag);
    bit ar, aw, ai;
    logic [7:0] ad;
    wr_rst_i = r ^ pol; wr_en_i = w ^ pol; in_en_i = i ^ pol; din_i = d;
    @(posedge clk);
    if (late) begin
      ar = pr; aw = pw; ai = pi; ad = pd;
      pr = r; pw = w; pi = i; pd = d;
    end else begin
      ar = r; aw = w; ai = i; ad = d;
    end
    if (ar) begin
      eptr = '0; ecnt = 0;
    end else if (aw) begin
      if (ai) begin
        emem[eptr] = ad;
        if (ecnt < MIN_RUN) ecnt++;
      end
      eptr = eptr + 1'b1;
    end
    @(negedge clk);
    chk(tag, int'(wr_ptr_o), int'(eptr));
    chk("R8 run flag", int'(run_ok_o), (ecnt >= MIN_RUN) ? 1 : 0);
  endtask

  task automatic readback();
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr_i = AW'(a);
      @(posedge clk);
      @(negedge clk);
      chk("R4 R5 stored contents", int'(rd_data_o), int'(emem[a]));
    end
  endtask

  task automatic suite(input bit p, input bit l);
    logic [AW-1:0] p0;
    blk_reset(p, l);
    step(1, 0, 0, 8'h00, "R2 reset pointer");
    step(0, 0, 0, 8'h00, "R3 idle");
    step(0, 0, 0, 8'h00, "R3 idle");
    // R6 R7: access timing of a single enabled step
    p0 = wr_ptr_o;
    step(0, 1, 0, 8'h00, "R4 step");
    chk("R6 R7 access start", int'(wr_ptr_o), l ? int'(p0) : int'(p0 + 1'b1));
    step(0, 0, 0, 8'h00, "R3 idle");
    chk("R6 R7 access settled", int'(wr_ptr_o), int'(p0 + 1'b1));
    step(1, 0, 0, 8'h00, "R2 reset pointer");
    step(0, 0, 0, 8'h00, "R3 idle");
    step(0, 0, 0, 8'h00, "R3 idle");
    // R5 R10: fill all locations, wrapping the pointer
    for (int k = 0; k < DEPTH; k++)
      step(0, 1, 1, 8'(k * 7 + 3), "R5 full write");
    step(0, 0, 0, 8'h00, "R3 idle");
    chk("R10 pointer wrapped", int'(wr_ptr_o), 0);
    // R4: alternate masked and unmasked cycles
    for (int k = 0; k < DEPTH; k++)
      step(0, 1, k[0], 8'(k) ^ 8'hA5, "R4 masked sweep");
    for (int k = 0; k < 3; k++)
      step(0, 0, 1, 8'h11, "R3 hold with input enable");
    for (int k = 0; k < 5; k++)
      step(0, 1, 1, 8'h40 + 8'(k), "R5 full write");
    step(1, 1, 1, 8'hEE, "R2 reset ignores enables");
    step(0, 0, 0, 8'h00, "R3 idle");
    step(0, 0, 0, 8'h00, "R3 idle");
    chk("R2 pointer after reset", int'(wr_ptr_o), 0);
    readback();
    // R8: exact run length
    for (int k = 0; k < MIN_RUN; k++)
      step(0, 1, 1, 8'(k), "R8 run write");
    step(0, 0, 0, 8'h00, "R3 idle");
    chk("R8 run flag reached", int'(run_ok_o), 1);
    step(1, 0, 0, 8'h00, "R2 reset pointer");
    step(0, 0, 0, 8'h00, "R3 idle");
    step(0, 0, 0, 8'h00, "R3 idle");
    chk("R8 run flag cleared", int'(run_ok_o), 0);
    // R9: spacing of write resets
    chk("R9 legal spacing", int'(space_err_o), 0);
    step(1, 0, 0, 8'h00, "R2 reset pointer");
    step(0, 0, 0, 8'h00, "R3 idle");
    step(1, 0, 0, 8'h00, "R2 reset pointer");
    step(0, 0, 0, 8'h00, "R3 idle");
    step(0, 0, 0, 8'h00, "R3 idle");
    chk("R9 short spacing flagged", int'(space_err_o), 1);
    step(0, 0, 0, 8'h00, "R3 idle");
    chk("R9 flag sticky", int'(space_err_o), 1);
    // R11: strap moved during operation
    chk("R11 strap flag clear", int'(strap_err_o), 0);
    strap_late = ~l;
    @(posedge clk);
    @(negedge clk);
    chk("R11 strap change flagged", int'(strap_err_o), 1);
    strap_late = l;
    @(posedge clk);
    @(negedge clk);
    chk("R11 strap flag sticky", int'(strap_err_o), 1);
  endtask

  bit finished = 1'b0;

  initial begin
    @(negedge clk);
    suite(1'b0, 1'b0);
    suite(1'b0, 1'b1);
    suite(1'b1, 1'b0);
    suite(1'b1, 1'b1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule